// File: doc/BRIEF.md
# Asynchronous Byte-Wide Static Memory Model

This block is a clockless behavioural model of an asynchronous static memory holding bytes. Three active-low strobes select its behaviour: a chip select, a write strobe and an output gate. The bidirectional byte bus is split into a data input, a data output and an output-drive qualifier, so the model can sit behind a pad ring or a bus fabric. The bus is driven only while `dout_en` is high.

A write opens when chip select and write strobe are both low. It closes at the first rising edge of either strobe, and the byte present on `din` at that closing edge is stored. Reads are purely combinational: while the part is selected for reading, `dout` follows the address and the array contents without any clock. A power indication output tells whether the part is in low-power standby or active.

The address is 19 bits wide. The storage depth is a parameter, so an integration or a test can use a small array. Out-of-range addresses fold onto the array by dropping the upper address bits.

Top module: `asr_byte_model`

## Requirements
- R1: With `ce_n`=0, `we_n`=1 and `oe_n`=0, `dout_en` is 1 and `dout` equals the byte last stored at the addressed location.
- R2: While the read condition of R1 holds, a change of `addr` alone changes `dout` to the byte at the new location, with no strobe edge needed.
- R3: With `ce_n`=1, `dout_en` is 0 and `pwr_active` is 0 whatever `we_n` and `oe_n` are. Pulsing `we_n` low during standby stores nothing.
- R4: With `ce_n`=0 and `we_n`=0, the part is writing: `dout_en` is 0 whether `oe_n` is 0 or 1.
- R5: Only the value on `din` at the edge that ends the write is stored. Other values presented earlier in the same write are lost.
- R6: A write ends, and commits, on whichever of `we_n` or `ce_n` rises first. If `we_n` rises while `ce_n`=0 and `oe_n`=0, the freshly written byte is driven at once.
- R7: If `ce_n` and `we_n` rise at the same instant, the write still commits and `dout_en` stays 0 throughout.
- R8: With `ce_n`=0, `we_n`=1 and `oe_n`=1, `dout_en` is 0 and `pwr_active` is 1.
- R9: `pwr_active` is 1 in every mode with `ce_n`=0.
- R10: The location used is `addr` modulo `DEPTH`, where `DEPTH` is a power of two, i.e. the low log2(`DEPTH`) address bits.
- R11: `dout` is all zeros whenever `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W (19) | Word address |
| din | input | DATA_W (8) | Byte presented for writing |
| dout | output | DATA_W (8) | Byte read out; zero when not driving |
| dout_en | output | 1 | High when the byte bus should be driven |
| pwr_active | output | 1 | High when selected, low in standby |

## Verification
Every output is a combinational function of the strobes, the address and the array, so each result is due in the same cycle as the stimulus that causes it. A stored byte is due immediately after the edge that closes the write. The bench changes inputs only on falling clock edges and queues one expected result per change. The monitor compares that result at the next rising edge, half a period later, when the combinational paths have settled and no input is moving.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;

    // Operating mode decoded from the three active-low strobes.
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,   // deselected, low power
        MODE_READ    = 2'd1,   // selected, driving stored byte
        MODE_WRITE   = 2'd2,   // selected, bus acts as input
        MODE_QUIET   = 2'd3    // selected, outputs disabled
    } asr_mode_e;

    // Decoder result bundle.
    typedef struct packed {
        asr_mode_e mode;
        logic      wr_window;
        logic      pwr_active;
    } asr_dec_t;

endpackage

// File: rtl/asr_mode_dec.sv
`timescale 1ns/1ps
module asr_mode_dec
    import asr_pkg::*;
(
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    output asr_mode_e mode,
    output logic      wr_window,
    output logic      pwr_active
);

    asr_dec_t dec_d;

    // Truth table: chip select dominates, then the write strobe
    // overrides the output gate.
    always_comb begin
        dec_d = '{mode: MODE_STANDBY, wr_window: 1'b0, pwr_active: 1'b0};
        if (!ce_n) begin
            dec_d.pwr_active = 1'b1;
            if (!we_n) begin
                dec_d.mode      = MODE_WRITE;
                dec_d.wr_window = 1'b1;
            end else if (!oe_n) begin
                dec_d.mode = MODE_READ;
            end else begin
                dec_d.mode = MODE_QUIET;
            end
        end
    end

    assign mode       = dec_d.mode;
    assign wr_window  = dec_d.wr_window;
    assign pwr_active = dec_d.pwr_active;

endmodule

// File: rtl/asr_store.sv
`timescale 1ns/1ps
module asr_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 19,
    parameter int DEPTH  = 2048     // must be a power of two, >= 2
) (
    input  logic              wr_window,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } commit_t;

    commit_t           cmt_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  rd_idx;

    // Fold the address onto the array by keeping the low bits only.
    always_comb begin
        cmt_d.idx  = addr[IDX_W-1:0];
        cmt_d.data = din;
    end

    // The write window closes when either strobe rises; the falling
    // edge of the window is the commit instant and captures the address
    // and byte present at that moment.
    always_ff @(negedge wr_window) begin
        mem_q[cmt_d.idx] <= cmt_d.data;
    end

    assign rd_idx  = addr[IDX_W-1:0];
    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/asr_io_stage.sv
`timescale 1ns/1ps
module asr_io_stage
    import asr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  asr_mode_e         mode,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              en;
    } bus_t;

    bus_t bus_d;

    // Drive only in read mode; keep the data lines at zero otherwise so
    // a downstream wired-OR or mux sees a clean idle value.
    always_comb begin
        bus_d = '{data: '0, en: 1'b0};
        if (mode == MODE_READ) begin
            bus_d.en   = 1'b1;
            bus_d.data = rd_data;
        end
    end

    assign dout    = bus_d.data;
    assign dout_en = bus_d.en;

endmodule

// File: rtl/asr_byte_model.sv
`timescale 1ns/1ps
module asr_byte_model
    import asr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 19,
    parameter int DEPTH  = 2048
) (
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              pwr_active
);

    asr_mode_e         mode;
    logic              wr_window;
    logic [DATA_W-1:0] rd_data;

    asr_mode_dec u_dec (
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .mode       (mode),
        .wr_window  (wr_window),
        .pwr_active (pwr_active)
    );

    asr_store #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .wr_window (wr_window),
        .addr      (addr),
        .din       (din),
        .rd_data   (rd_data)
    );

    asr_io_stage #(
        .DATA_W (DATA_W)
    ) u_io (
        .mode    (mode),
        .rd_data (rd_data),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // Port-level checks of the strobe truth table against the outputs
    // produced by the decoder and output stage.
    always_comb begin
        if (ce_n) begin
            a_r3_standby_quiet: assert (!dout_en && !pwr_active)
                else $error("R3: standby must float bus and drop power flag");
        end
        if (!ce_n && !we_n) begin
            a_r4_write_floats: assert (!dout_en)
                else $error("R4: bus driven during write");
        end
        if (!ce_n && we_n && !oe_n) begin
            a_r1_read_drives: assert (dout_en)
                else $error("R1: read mode must drive bus");
        end
        if (!ce_n && we_n && oe_n) begin
            a_r8_selected_quiet: assert (!dout_en && pwr_active)
                else $error("R8: selected-disabled state wrong");
        end
        if (!ce_n) begin
            a_r9_power_active: assert (pwr_active)
                else $error("R9: power flag low while selected");
        end
        if (!dout_en) begin
            a_r11_idle_zero: assert (dout == '0)
                else $error("R11: data lines not zero while idle");
        end
    end

endmodule

// File: tb/asr_byte_model_bench.sv
`timescale 1ns/1ps
module asr_byte_model_bench;

    localparam int DEPTH  = 256;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int ADDR_W = 19;

    logic              clk = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din  = '0;
    logic [7:0]        dout;
    logic              dout_en;
    logic              pwr_active;

    always #2.5 clk = ~clk;   // 200 MHz pacing clock

    asr_byte_model #(.DEPTH(DEPTH)) u_asr_byte_model (
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .din        (din),
        .dout       (dout),
        .dout_en    (dout_en),
        .pwr_active (pwr_active)
    );

    typedef struct {
        string      tag;
        logic       en;
        logic [7:0] data;
        logic       pwr;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;
    logic [7:0] model [DEPTH];

    function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    task automatic push(input string tag, input logic en,
                        input logic [7:0] d, input logic pwr);
        exp_t e;
        e.tag = tag; e.en = en; e.data = d; e.pwr = pwr;
        sb_q.push_back(e);
    endtask

    // Apply one input vector on a falling edge.
    task automatic drive(input logic c, input logic w, input logic o,
                         input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr = a; din = d;
    endtask

    // endmode: 0 = write strobe rises first, 1 = chip select rises first,
    // 2 = both rise together.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                            input int endmode, input logic o);
        drive(1'b0, 1'b0, o, a, ~d);
        push("R4 write opens, bus floats", 1'b0, 8'h00, 1'b1);
        drive(1'b0, 1'b0, o, a, d);
        push("R4 write held, bus floats", 1'b0, 8'h00, 1'b1);
        model[fold(a)] = d;   // R5: the closing value is the stored one
        if (endmode == 0) begin
            drive(1'b0, 1'b1, o, a, d);
            if (!o) push("R6 write-strobe end, new byte driven", 1'b1, d, 1'b1);
            else    push("R8 write-strobe end, outputs disabled", 1'b0, 8'h00, 1'b1);
        end else if (endmode == 1) begin
            drive(1'b1, 1'b0, o, a, d);
            push("R6 chip-select end, standby", 1'b0, 8'h00, 1'b0);
        end else begin
            drive(1'b1, 1'b1, o, a, d);
            push("R7 simultaneous end stays floating", 1'b0, 8'h00, 1'b0);
        end
        drive(1'b1, 1'b1, 1'b1, a, 8'h00);
        push("R3 deselected after write", 1'b0, 8'h00, 1'b0);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
        drive(1'b0, 1'b1, 1'b0, a, 8'h00);
        push(tag, 1'b1, model[fold(a)], 1'b1);
    endtask

    // Monitor: compare one queued expectation at each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (dout_en !== e.en || dout !== e.data || pwr_active !== e.pwr) begin
                    fails++;
                    $display("FAIL %s: got en=%b data=%h pwr=%b expected en=%b data=%h pwr=%b",
                             e.tag, dout_en, dout, pwr_active, e.en, e.data, e.pwr);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset-state check: deselected
        drive(1'b1, 1'b1, 1'b1, '0, 8'h00);
        push("R3 initial standby", 1'b0, 8'h00, 1'b0);

        // Fill every location, cycling through the three ending styles
        for (int i = 0; i < DEPTH; i++) begin
            do_write(ADDR_W'(i), 8'(i * 37 + 11), i % 3, 1'b1);
        end

        // R1: plain reads at several locations
        do_read(ADDR_W'(0),   "R1 read loc 0");
        do_read(ADDR_W'(200), "R1 read loc 200");
        do_read(ADDR_W'(255), "R1 read top loc");

        // R2: address-only changes while selected for read
        for (int i = 1; i < 9; i++) begin
            drive(1'b0, 1'b1, 1'b0, ADDR_W'(i * 29), 8'h00);
            push("R2 read follows address", 1'b1, model[fold(ADDR_W'(i * 29))], 1'b1);
        end

        // R4: write with output gate low still floats; R6 drive-through
        do_write(ADDR_W'(17), 8'hC3, 0, 1'b0);
        do_read(ADDR_W'(17), "R5 stored closing byte");

        // R8/R9: selected with outputs disabled
        drive(1'b0, 1'b1, 1'b1, ADDR_W'(17), 8'h00);
        push("R8 selected quiet", 1'b0, 8'h00, 1'b1);

        // R3: write strobe pulses during standby store nothing
        drive(1'b1, 1'b0, 1'b0, ADDR_W'(40), 8'hEE);
        push("R3 standby ignores write strobe", 1'b0, 8'h00, 1'b0);
        drive(1'b1, 1'b1, 1'b0, ADDR_W'(40), 8'hEE);
        push("R3 standby ignores output gate", 1'b0, 8'h00, 1'b0);
        do_read(ADDR_W'(40), "R3 location unchanged after standby pulse");

        // R6/R7 explicit cases on fresh values
        do_write(ADDR_W'(90), 8'h3C, 1, 1'b0);
        do_read(ADDR_W'(90), "R6 chip-select ended write stored");
        do_write(ADDR_W'(91), 8'hA5, 2, 1'b0);
        do_read(ADDR_W'(91), "R7 simultaneous end stored");

        // R10: address folding
        do_write(19'h00105, 8'h5A, 0, 1'b1);
        do_read(ADDR_W'(5), "R10 folded write lands at low index");
        do_read(19'h7FF05, "R10 high alias reads same location");

        drive(1'b1, 1'b1, 1'b1, '0, 8'h00);
        push("R11 idle bus zero", 1'b0, 8'h00, 1'b0);

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule